// File: doc/BRIEF.md
# Timer Overflow Status and Interrupt Logic

This block turns the overflow pulses of two free-running timers (A and B) into sticky status flags and a single active-high interrupt line. Software controls it through one control register. That register holds a per-timer enable bit and accepts a per-timer reset strobe. The status byte shows which timers have overflowed. It is one plain output, and the same byte serves every read address of the surrounding chip, so there is no alternate page and no identification register.

Each timer follows a small protocol. The first enabled overflow raises its flag and its interrupt request. The request stays up until software writes the reset bit. If a second overflow arrives before that write, the interrupt is considered missed. The request is then dropped and that timer stays silent until the reset is written. The reset write does not re-raise the line; the next qualifying overflow does. Missed interrupts can still be seen, because the flag stays set.

Top module: `tmr_irq_status`

## Requirements
- R1: When a timer's overflow pulse arrives with its enable bit set, its flag clear and no reset strobe in that cycle, the timer's status flag and its interrupt request both become 1 at the next clock edge.
- R2: A raised interrupt request stays at 1 until a reset strobe or another enabled overflow of that timer arrives.
- R3: An enabled overflow while the timer's request is 1 drops the request and leaves the flag at 1. After that, enabled overflows of that timer leave the request at 0 until its reset strobe.
- R4: A control write with bit 4 (Timer A) or bit 5 (Timer B) at 1 clears that timer's flag, request and suppression at the next edge and never raises the request. These reset bits act only in the write cycle and are not stored.
- R5: Enable bits are bit 2 (Timer A) and bit 3 (Timer B) of the control register. They are stored on every control write and take effect from the following cycle. An overflow while the bit is 0 changes neither flag nor request.
- R6: The status byte carries the Timer A flag in bit 0 and the Timer B flag in bit 1, with bits 7..2 at 0. The interrupt output is the OR of the two requests. After synchronous reset, the status byte, the interrupt output and the enable bits are all 0.
- R7: The two timers are independent: overflows, enables and reset strobes of one never change the flag or request of the other.
- R8: A reset strobe in the same cycle as an overflow of that timer wins: the overflow is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovf_a | input | 1 | Timer A overflow pulse, one cycle |
| ovf_b | input | 1 | Timer B overflow pulse, one cycle |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 8 | Control register write data |
| status | output | 8 | Status byte (bit 0 A flag, bit 1 B flag) |
| irq | output | 1 | Active-high interrupt output |

## Verification
The bench goes after the missed-interrupt path. A second overflow without a reset must drop the line, and a third must keep it down. A design that only ever sets the request would leave the line high forever. A design that drops the flag along with the request would hide the missed interrupt. The reset write that follows must not re-raise the line, which catches designs that treat the reset as a retrigger. The bench also drives a reset strobe and an overflow in the same cycle, overflows while the enable bit is 0, and control writes without reset bits after a reset. These expose a wrong priority, ignored enables, and reset bits that were latched instead of pulsed.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int NUM_TMR = 2;

  typedef struct packed {
    logic flag;
    logic req;
    logic supp;
  } tmr_state_t;
endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode #(
  parameter int CTL_W   = 8,
  parameter int N       = 2,
  parameter int EN_LSB  = 2,
  parameter int RST_LSB = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output logic [N-1:0]     en,
  output logic [N-1:0]     clr
);
  logic [CTL_W-1:0] wdata_unused;
  assign wdata_unused = wdata;

  always_ff @(posedge clk) begin
    if (rst)     en <= '0;
    else if (wr) en <= wdata[EN_LSB +: N];
  end

  assign clr = wr ? wdata[RST_LSB +: N] : '0;
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit
  import tmr_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ovf,
  input  logic en,
  input  logic clr,
  output logic flag,
  output logic req
);
  tmr_state_t st;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st <= '0;
    end else if (ovf && en && !st.supp) begin
      if (!st.flag) begin
        st.flag <= 1'b1;
        st.req  <= 1'b1;
      end else if (st.req) begin
        st.req  <= 1'b0;
        st.supp <= 1'b1;
      end
    end
  end

  assign flag = st.flag;
  assign req  = st.req;
endmodule

// File: rtl/tmr_irq_status.sv
module tmr_irq_status
  import tmr_irq_pkg::*;
#(
  parameter int CTL_W   = 8,
  parameter int STAT_W  = 8,
  parameter int EN_LSB  = 2,
  parameter int RST_LSB = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ovf_a,
  input  logic              ovf_b,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_data,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  localparam int N = NUM_TMR;

  logic [N-1:0] ovf_v;
  logic [N-1:0] en_q;
  logic [N-1:0] rst_stb;
  logic [N-1:0] flag_v;
  logic [N-1:0] req_v;

  assign ovf_v = {ovf_b, ovf_a};

  tmr_ctl_decode #(
    .CTL_W(CTL_W), .N(N), .EN_LSB(EN_LSB), .RST_LSB(RST_LSB)
  ) u_dec (
    .clk(clk), .rst(rst), .wr(ctl_wr), .wdata(ctl_data),
    .en(en_q), .clr(rst_stb)
  );

  for (genvar i = 0; i < N; i++) begin : g_tmr
    tmr_flag_unit u_unit (
      .clk(clk), .rst(rst), .ovf(ovf_v[i]), .en(en_q[i]),
      .clr(rst_stb[i]), .flag(flag_v[i]), .req(req_v[i])
    );
  end

  assign status = {{(STAT_W-N){1'b0}}, flag_v};
  assign irq    = |req_v;
endmodule

// File: rtl/tmr_irq_status_chk.sv
module tmr_irq_status_chk #(
  parameter int N      = 2,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [N-1:0]      ovf,
  input logic [N-1:0]      en,
  input logic [N-1:0]      clr,
  input logic [N-1:0]      flag,
  input logic [N-1:0]      req,
  input logic [STAT_W-1:0] status,
  input logic              irq
);
  for (genvar i = 0; i < N; i++) begin : g_t
    // R1
    set_on_ovf_chk: assert property (@(posedge clk) disable iff (rst)
      (ovf[i] && en[i] && !flag[i] && !clr[i]) |=> (flag[i] && req[i]));
    // R2
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
      (req[i] && !ovf[i] && !clr[i]) |=> req[i]);
    // R3
    drop_on_repeat_chk: assert property (@(posedge clk) disable iff (rst)
      (ovf[i] && en[i] && req[i] && !clr[i]) |=> (!req[i] && flag[i]));
    // R3
    stay_low_chk: assert property (@(posedge clk) disable iff (rst)
      (ovf[i] && flag[i] && !req[i] && !clr[i]) |=> !req[i]);
    // R4
    clear_chk: assert property (@(posedge clk) disable iff (rst)
      clr[i] |=> (!flag[i] && !req[i]));
    // R5
    no_enable_chk: assert property (@(posedge clk) disable iff (rst)
      (ovf[i] && !en[i] && !clr[i]) |=> ($stable(flag[i]) && $stable(req[i])));
  end

  // R6
  irq_has_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|status[N-1:0]));
endmodule

bind tmr_irq_status tmr_irq_status_chk #(.N(N), .STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst(rst), .ovf(ovf_v), .en(en_q), .clr(rst_stb),
  .flag(flag_v), .req(req_v), .status(status), .irq(irq)
);

// File: tb/tmr_irq_status_tb.sv
`timescale 1ns/1ps
module tmr_irq_status_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ovf_a = 1'b0, ovf_b = 1'b0, ctl_wr = 1'b0;
  logic [7:0] ctl_data = 8'h00;
  logic [7:0] status;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m_flag[2];
  int m_req[2];
  int m_supp[2];
  int m_en[2];

  always #2.5 clk = ~clk;

  tmr_irq_status u_dut (
    .clk(clk), .rst(rst), .ovf_a(ovf_a), .ovf_b(ovf_b),
    .ctl_wr(ctl_wr), .ctl_data(ctl_data), .status(status), .irq(irq)
  );

  task automatic compare(input string tag);
    logic [7:0] es;
    logic       ei;
    es = {6'b0, m_flag[1] != 0, m_flag[0] != 0};
    ei = (m_req[0] != 0) || (m_req[1] != 0);
    checks++;
    if (status !== es || irq !== ei) begin
      fails++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b", tag, status, irq, es, ei);
    end
  endtask

  task automatic step(input logic oa, input logic ob, input logic w,
                      input logic [7:0] d, input string tag);
    int ov[2];
    @(negedge clk);
    ovf_a = oa; ovf_b = ob; ctl_wr = w; ctl_data = d;
    ov[0] = oa; ov[1] = ob;
    for (int i = 0; i < 2; i++) begin
      if (w && d[4+i]) begin
        m_flag[i] = 0; m_req[i] = 0; m_supp[i] = 0;
      end else if (ov[i] != 0 && m_en[i] != 0 && m_supp[i] == 0) begin
        if (m_flag[i] == 0) begin
          m_flag[i] = 1; m_req[i] = 1;
        end else if (m_req[i] != 0) begin
          m_req[i] = 0; m_supp[i] = 1;
        end
      end
    end
    if (w) begin
      m_en[0] = d[2]; m_en[1] = d[3];
    end
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 2; i++) begin
      m_flag[i] = 0; m_req[i] = 0; m_supp[i] = 0; m_en[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    compare("R6 reset state");

    step(1,1,0,8'h00,"R5 overflow before enable");
    step(0,0,1,8'h0C,"R5 enable both");
    step(1,0,0,8'h00,"R1 first A overflow");
    step(0,0,0,8'h00,"R2 hold");
    step(0,0,0,8'h00,"R2 hold");
    step(0,0,1,8'h1C,"R4 reset A");
    step(0,0,0,8'h00,"R4 after reset");
    step(1,0,0,8'h00,"R1 A again");
    step(1,0,0,8'h00,"R3 missed drop");
    step(0,0,0,8'h00,"R3 stays low");
    step(1,0,0,8'h00,"R3 suppressed");
    step(0,0,1,8'h1C,"R4 no re-raise");
    step(0,0,0,8'h00,"R4 still low");
    step(1,0,0,8'h00,"R1 rearmed");
    step(0,1,0,8'h00,"R7 B sets");
    step(0,0,1,8'h1C,"R7 clear A only");
    step(0,1,0,8'h00,"R3 B drop");
    step(1,1,1,8'h3C,"R8 reset beats overflow");
    step(0,0,0,8'h00,"R8 idle");
    step(0,0,1,8'h04,"R5 disable B");
    step(0,1,0,8'h00,"R5 B ignored");
    step(1,0,0,8'h00,"R6 A only");
    step(0,0,1,8'h34,"R4 reset bits");
    step(0,0,1,8'h00,"R5 disable all");
    step(1,1,0,8'h00,"R5 both ignored");
    step(0,0,1,8'h0C,"R4 no stored reset");
    step(1,1,0,8'h00,"R4 both set");
    step(0,0,0,8'h00,"R6 OR of both");

    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      logic wbit;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wbit = (lfsr[7:5] == 3'b000);
      step(lfsr[0] & lfsr[3], lfsr[1] & lfsr[4], wbit,
           {lfsr[15:14], lfsr[11:10] | 2'b00, lfsr[9:8] | {lfsr[2], lfsr[2]}, lfsr[13:12]},
           "R2 R7 mixed traffic");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule